// File: doc/BRIEF.md
# Power-Management Event Interrupt Controller

This block gathers single-cycle event pulses from power-management and system sources and converts them into two interrupt outputs for the rest of the chip. The first is an active-low system-management interrupt to the processor. The second is a level-sensitive ACPI system control interrupt. Every source owns a sticky status flag, an enable flag and a routing flag. The routing flag steers the source to the management interrupt (0) or to the control interrupt (1).

The management interrupt uses a handshake. Once asserted, it stays low until software sets the end-of-interrupt flag. It is then released for a guaranteed number of clocks before it may assert again. The control interrupt is a plain level. It stays active while any enabled source that is routed to it has its status set. It reports a programmable IRQ number and adjusts its polarity to match that number.

Software reaches all state through a single-cycle register port. Address 0 is status (write 1 to clear). Address 1 is enable. Address 2 is routing. Address 3 is control: bit 0 is the management-interrupt gate, bit 1 is end-of-interrupt, and bit 2 selects APIC mode. Address 4 is the IRQ number in bits 4:0. Read data is combinational from the address.

Top module: `pm_event_irq_ctrl`

## Requirements
- R1: After reset, status, enable, routing and control read 0, the IRQ number reads 9, smi_n is 1 and sci_out is 0.
- R2: An event pulse sets its status bit whether or not the bit is enabled. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event pulse in the same cycle as a clear of that bit leaves the bit set.
- R3: With the gate (control bit 0) set, smi_n goes low one clock after the status of an enabled source with routing 0 becomes visible. Sources that are disabled or have routing 1 never drive it low, and neither does any source while the gate is clear.
- R4: Once low, smi_n stays low until software writes 1 to control bit 1 (end-of-interrupt).
- R5: After end-of-interrupt, smi_n is high for exactly GAP_CYC clocks if a qualifying source is still pending, and then goes low again. If no source is pending, it stays high.
- R6: sci_out is active for as long as at least one enabled source with routing 1 has its status set. It goes inactive when the last such status is cleared.
- R7: When control bit 2 is 0, the IRQ number may only be 9, 10 or 11. When bit 2 is 1, it may also be 20 to 23. A write of any other value is ignored and the previous number is kept.
- R8: sci_out is active-high when the IRQ number is below 20 (not shared). It is active-low when the IRQ number is 20 to 23 (shared with a PCI interrupt line).
- R9: Writing control with bit 2 cleared while the IRQ number is 20 or above sets the IRQ number back to 9.
- R10: The end-of-interrupt bit reads 1 after it is written and returns to 0 on the clock at which smi_n next goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | N_EVT | One-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |
| smi_n | output | 1 | Active-low system-management interrupt |
| sci_out | output | 1 | System control interrupt, polarity per R8 |
| sci_irq | output | 5 | Selected IRQ number for the control interrupt |

## Verification
The bench builds the block with its defaults: eight sources, a 16-bit register port, a four-clock release gap and a combinational control-interrupt output. With eight sources, one routing byte can mix management-routed, control-routed and disabled sources, so masking and steering are checked together. The short gap lets the bench count every high clock between two assertions and compare the count with GAP_CYC directly. The IRQ table walks both modes, including illegal values, so routing and polarity are covered on both sides of the shared boundary.

// File: rtl/pm_irq_pkg.sv
`timescale 1ns/1ps
package pm_irq_pkg;

   typedef enum logic [2:0] {
      ADDR_STATUS = 3'd0,
      ADDR_ENABLE = 3'd1,
      ADDR_ROUTE  = 3'd2,
      ADDR_CTRL   = 3'd3,
      ADDR_IRQ    = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      SMI_IDLE   = 2'd0,
      SMI_ACTIVE = 2'd1,
      SMI_GAP    = 2'd2
   } smi_state_e;

   localparam int CTRL_GATE_BIT = 0;
   localparam int CTRL_EOS_BIT  = 1;
   localparam int CTRL_APIC_BIT = 2;
   localparam int IRQ_W         = 5;

   localparam logic [IRQ_W-1:0] IRQ_RESET = 5'd9;

   // Legal IRQ numbers for the current interrupt-controller mode.
   function automatic logic irq_legal(input logic [IRQ_W-1:0] irq, input logic apic);
      logic legacy_ok;
      logic apic_ok;
      legacy_ok = (irq >= 5'd9) && (irq <= 5'd11);
      apic_ok   = apic && (irq >= 5'd20) && (irq <= 5'd23);
      return legacy_ok || apic_ok;
   endfunction

   // IRQ numbers 20..23 share a line with PCI interrupts.
   function automatic logic irq_shared(input logic [IRQ_W-1:0] irq);
      return irq >= 5'd20;
   endfunction

endpackage

// File: rtl/pm_evt_bank.sv
`timescale 1ns/1ps
module pm_evt_bank #(
   parameter int N_EVT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_pulse,
   input  logic             wr_status,
   input  logic             wr_enable,
   input  logic             wr_route,
   input  logic [N_EVT-1:0] wdata,
   output logic [N_EVT-1:0] status,
   output logic [N_EVT-1:0] enable,
   output logic [N_EVT-1:0] route,
   output logic             smi_pend,
   output logic             sci_pend
);

   generate
      for (genvar i = 0; i < N_EVT; i++) begin : g_src
         logic st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               st_q <= 1'b0;
            else if (evt_pulse[i])
               st_q <= 1'b1;
            else if (wr_status && wdata[i])
               st_q <= 1'b0;
         end
         assign status[i] = st_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= '0;
         route  <= '0;
      end else begin
         if (wr_enable) enable <= wdata;
         if (wr_route)  route  <= wdata;
      end
   end

   logic [N_EVT-1:0] live;
   assign live     = status & enable;
   assign smi_pend = |(live & ~route);
   assign sci_pend = |(live & route);

endmodule

// File: rtl/pm_smi_seq.sv
`timescale 1ns/1ps
module pm_smi_seq
   import pm_irq_pkg::*;
#(
   parameter int GAP_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smi_req,
   input  logic eos_set,
   output logic smi_n,
   output logic eos
);

   localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(GAP_CYC - 1);

   generate
      if (GAP_CYC < 4) begin : g_bad_gap
         $error("pm_smi_seq: GAP_CYC must be at least 4");
      end
   endgenerate

   smi_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             eos_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         SMI_IDLE:   if (smi_req) state_d = SMI_ACTIVE;
         SMI_ACTIVE: if (eos_q) begin
                        state_d = SMI_GAP;
                        cnt_d   = CNT_LOAD;
                     end
         SMI_GAP:    if (cnt_q == '0)
                        state_d = smi_req ? SMI_ACTIVE : SMI_IDLE;
                     else
                        cnt_d = cnt_q - 1'b1;
         default:    state_d = SMI_IDLE;
      endcase
   end

   logic entering;
   assign entering = (state_d == SMI_ACTIVE) && (state_q != SMI_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SMI_IDLE;
         cnt_q   <= '0;
         eos_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (entering)
            eos_q <= 1'b0;
         else if (eos_set)
            eos_q <= 1'b1;
      end
   end

   assign smi_n = (state_q != SMI_ACTIVE);
   assign eos   = eos_q;

endmodule

// File: rtl/pm_sci_route.sv
`timescale 1ns/1ps
module pm_sci_route
   import pm_irq_pkg::*;
#(
   parameter bit SCI_REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sci_pend,
   input  logic             ctrl_wr,
   input  logic             apic_wdata,
   input  logic             irq_wr,
   input  logic [IRQ_W-1:0] irq_wdata,
   output logic             apic,
   output logic [IRQ_W-1:0] sci_irq,
   output logic             sci_out
);

   logic             apic_q;
   logic [IRQ_W-1:0] irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         apic_q <= 1'b0;
         irq_q  <= IRQ_RESET;
      end else begin
         if (ctrl_wr) apic_q <= apic_wdata;
         if (irq_wr && irq_legal(irq_wdata, apic_q))
            irq_q <= irq_wdata;
         else if (ctrl_wr && !apic_wdata && !irq_legal(irq_q, 1'b0))
            irq_q <= IRQ_RESET;
      end
   end

   logic pin_d;
   assign pin_d = irq_shared(irq_q) ? ~sci_pend : sci_pend;

   generate
      if (SCI_REG_OUT) begin : g_flop
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= pin_d;
         end
         assign sci_out = pin_q;
      end else begin : g_comb
         assign sci_out = pin_d;
      end
   endgenerate

   assign apic    = apic_q;
   assign sci_irq = irq_q;

endmodule

// File: rtl/pm_event_irq_ctrl.sv
`timescale 1ns/1ps
module pm_event_irq_ctrl
   import pm_irq_pkg::*;
#(
   parameter int N_EVT       = 8,
   parameter int REG_W       = 16,
   parameter int GAP_CYC     = 4,
   parameter bit SCI_REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_pulse,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             smi_n,
   output logic             sci_out,
   output logic [4:0]       sci_irq
);

   generate
      if (N_EVT < 1 || N_EVT > REG_W) begin : g_bad_nevt
         $error("pm_event_irq_ctrl: N_EVT must be 1..REG_W");
      end
      if (REG_W < IRQ_W) begin : g_bad_regw
         $error("pm_event_irq_ctrl: REG_W too narrow for IRQ field");
      end
   endgenerate

   logic wr_status, wr_enable, wr_route, wr_ctrl, wr_irq;
   assign wr_status = reg_we && (reg_addr == ADDR_STATUS);
   assign wr_enable = reg_we && (reg_addr == ADDR_ENABLE);
   assign wr_route  = reg_we && (reg_addr == ADDR_ROUTE);
   assign wr_ctrl   = reg_we && (reg_addr == ADDR_CTRL);
   assign wr_irq    = reg_we && (reg_addr == ADDR_IRQ);

   logic [N_EVT-1:0] status, enable, route;
   logic             smi_pend, sci_pend;

   pm_evt_bank #(.N_EVT(N_EVT)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .wr_status (wr_status),
      .wr_enable (wr_enable),
      .wr_route  (wr_route),
      .wdata     (reg_wdata[N_EVT-1:0]),
      .status    (status),
      .enable    (enable),
      .route     (route),
      .smi_pend  (smi_pend),
      .sci_pend  (sci_pend)
   );

   logic gate_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gate_q <= 1'b0;
      else if (wr_ctrl) gate_q <= reg_wdata[CTRL_GATE_BIT];
   end

   logic eos_q;
   pm_smi_seq #(.GAP_CYC(GAP_CYC)) u_smi (
      .clk     (clk),
      .rst_n   (rst_n),
      .smi_req (gate_q && smi_pend),
      .eos_set (wr_ctrl && reg_wdata[CTRL_EOS_BIT]),
      .smi_n   (smi_n),
      .eos     (eos_q)
   );

   logic apic_q;
   pm_sci_route #(.SCI_REG_OUT(SCI_REG_OUT)) u_sci (
      .clk        (clk),
      .rst_n      (rst_n),
      .sci_pend   (sci_pend),
      .ctrl_wr    (wr_ctrl),
      .apic_wdata (reg_wdata[CTRL_APIC_BIT]),
      .irq_wr     (wr_irq),
      .irq_wdata  (reg_wdata[IRQ_W-1:0]),
      .apic       (apic_q),
      .sci_irq    (sci_irq),
      .sci_out    (sci_out)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_STATUS: reg_rdata = REG_W'(status);
         ADDR_ENABLE: reg_rdata = REG_W'(enable);
         ADDR_ROUTE:  reg_rdata = REG_W'(route);
         ADDR_CTRL:   reg_rdata = REG_W'({apic_q, eos_q, gate_q});
         ADDR_IRQ:    reg_rdata = REG_W'(sci_irq);
         default:     reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pm_event_irq_chk.sv
`timescale 1ns/1ps
module pm_event_irq_chk #(
   parameter int N_EVT   = 8,
   parameter int GAP_CYC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smi_n,
   input logic             eos,
   input logic [N_EVT-1:0] status,
   input logic [N_EVT-1:0] evt_pulse,
   input logic             st_wr,
   input logic             apic,
   input logic [4:0]       sci_irq
);

   localparam int HC_W = $clog2(GAP_CYC + 1) + 1;

   // Clocks smi_n has been high, saturating; starts saturated after reset.
   logic [HC_W-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_cnt <= HC_W'(GAP_CYC);
      else if (!smi_n)
         hi_cnt <= '0;
      else if (hi_cnt < HC_W'(GAP_CYC))
         hi_cnt <= hi_cnt + 1'b1;
   end

   assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse == '0 && !st_wr) |=> $stable(status));

   assert_smi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_n && !eos) |=> !smi_n);

   assert_smi_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_n && $past(smi_n)) |-> (hi_cnt >= HC_W'(GAP_CYC)));

   assert_eos_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_n && $past(smi_n)) |-> !eos);

   assert_irq_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_irq inside {5'd9, 5'd10, 5'd11}) ||
      (apic && (sci_irq inside {5'd20, 5'd21, 5'd22, 5'd23})));

endmodule

bind pm_event_irq_ctrl pm_event_irq_chk #(.N_EVT(N_EVT), .GAP_CYC(GAP_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smi_n     (smi_n),
   .eos       (eos_q),
   .status    (status),
   .evt_pulse (evt_pulse),
   .st_wr     (wr_status),
   .apic      (apic_q),
   .sci_irq   (sci_irq)
);

// File: tb/pm_event_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pm_event_irq_ctrl_tb;

   localparam int N_EVT   = 8;
   localparam int REG_W   = 16;
   localparam int GAP_CYC = 4;

   localparam logic [2:0] A_ST = 3'd0, A_EN = 3'd1, A_RT = 3'd2, A_CT = 3'd3, A_IRQ = 3'd4;

   // {apic mode, value written, expected IRQ number}
   localparam int NVEC = 10;
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b0, 5'd10, 5'd10},
      {1'b0, 5'd20, 5'd10},
      {1'b0, 5'd12, 5'd10},
      {1'b0, 5'd11, 5'd11},
      {1'b1, 5'd21, 5'd21},
      {1'b1, 5'd8,  5'd21},
      {1'b1, 5'd23, 5'd23},
      {1'b1, 5'd24, 5'd23},
      {1'b1, 5'd9,  5'd9},
      {1'b1, 5'd22, 5'd22}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_EVT-1:0] evt_pulse = '0;
   logic             reg_we = 1'b0;
   logic [2:0]       reg_addr = '0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic             smi_n, sci_out;
   logic [4:0]       sci_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pm_event_irq_ctrl #(.N_EVT(N_EVT), .REG_W(REG_W), .GAP_CYC(GAP_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .smi_n(smi_n), .sci_out(sci_out), .sci_irq(sci_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [REG_W-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [REG_W-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [N_EVT-1:0] m);
      @(negedge clk);
      evt_pulse = m;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [REG_W-1:0] v;
      int hi;

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(A_ST, v);  chk("R1 status", v, 0);
      rd(A_EN, v);  chk("R1 enable", v, 0);
      rd(A_RT, v);  chk("R1 route", v, 0);
      rd(A_CT, v);  chk("R1 ctrl", v, 0);
      rd(A_IRQ, v); chk("R1 irq reg", v, 9);
      chk("R1 smi_n", smi_n, 1);
      chk("R1 sci_out", sci_out, 0);
      chk("R1 sci_irq", sci_irq, 9);

      // R2: sticky status, W1C, event beats clear
      pulse(8'h08);
      rd(A_ST, v); chk("R2 set while disabled", v, 16'h08);
      wr(A_ST, 16'h00);
      rd(A_ST, v); chk("R2 write 0 keeps", v, 16'h08);
      wr(A_ST, 16'h08);
      rd(A_ST, v); chk("R2 W1C", v, 0);
      @(negedge clk);
      evt_pulse = 8'h04; reg_we = 1'b1; reg_addr = A_ST; reg_wdata = 16'h04;
      @(negedge clk);
      evt_pulse = '0; reg_we = 1'b0;
      rd(A_ST, v); chk("R2 event wins over clear", v, 16'h04);
      wr(A_ST, 16'h04);

      // R3: disabled source with gate on does not assert
      wr(A_CT, 16'h1);
      pulse(8'h02);
      repeat (3) @(negedge clk);
      chk("R3 disabled source", smi_n, 1);
      wr(A_ST, 16'h02);

      // R3/R4/R5/R10: SMI handshake
      wr(A_EN, 16'h01);
      pulse(8'h01);
      chk("R3 not yet asserted", smi_n, 1);
      @(negedge clk);
      chk("R3 asserted", smi_n, 0);
      repeat (8) @(negedge clk);
      chk("R4 held low", smi_n, 0);
      wr(A_CT, 16'h3);
      chk("R4 low at eos edge", smi_n, 0);
      hi = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (smi_n) hi++;
         else break;
      end
      chk("R5 gap length", hi, GAP_CYC);
      chk("R5 reasserted", smi_n, 0);
      rd(A_CT, v); chk("R10 eos self-cleared", v, 16'h1);
      wr(A_ST, 16'h01);
      wr(A_CT, 16'h3);
      rd(A_CT, v); chk("R10 eos reads set", v, 16'h3);
      repeat (12) @(negedge clk);
      chk("R5 no reassert when idle", smi_n, 1);

      // R3: gate off blocks SMI
      wr(A_CT, 16'h0);
      wr(A_EN, 16'h02);
      pulse(8'h02);
      repeat (4) @(negedge clk);
      chk("R3 gate off", smi_n, 1);
      wr(A_ST, 16'h02);
      wr(A_EN, 16'h00);

      // R7/R8: IRQ selection table
      for (int i = 0; i < NVEC; i++) begin
         wr(A_CT, {13'd0, VEC[i][10], 2'b00});
         wr(A_IRQ, {11'd0, VEC[i][9:5]});
         chk("R7 sci_irq", sci_irq, VEC[i][4:0]);
         rd(A_IRQ, v); chk("R7 irq reg", v, {11'd0, VEC[i][4:0]});
         chk("R8 idle level", sci_out, (VEC[i][4:0] >= 5'd20) ? 1 : 0);
      end

      // R9: leaving APIC mode with a shared IRQ
      wr(A_CT, 16'h1);
      chk("R9 irq reverts", sci_irq, 9);

      // R6: SCI level behaviour
      wr(A_RT, 16'h30);
      wr(A_EN, 16'h30);
      pulse(8'h40);
      chk("R6 disabled source", sci_out, 0);
      pulse(8'h10);
      chk("R6 asserted", sci_out, 1);
      @(negedge clk);
      chk("R3 SCI-routed no SMI", smi_n, 1);
      pulse(8'h20);
      wr(A_ST, 16'h10);
      chk("R6 held by second source", sci_out, 1);
      wr(A_ST, 16'h20);
      chk("R6 released", sci_out, 0);

      // R8: shared IRQ active-low
      wr(A_CT, 16'h5);
      wr(A_IRQ, 16'd21);
      chk("R8 shared idle high", sci_out, 1);
      pulse(8'h10);
      chk("R8 shared active low", sci_out, 0);
      wr(A_ST, 16'h50);
      chk("R8 shared released", sci_out, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule